// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block collects eight interrupt request lines, resolves them by fixed priority and signals a processor through a single interrupt output. Software reaches it through two byte-wide register ports that share one write bus and one read bus. One select bit chooses between the command port and the data port. A short ordered sequence of writes sets the vector base, the cascade identity and the end-of-interrupt mode. After that sequence, writes to the data port load the mask.

When the processor answers with a one-cycle acknowledge pulse, the controller returns an 8-bit vector one cycle later. The vector's upper five bits come from the configured base and its lower three bits are the winning input number. The controller also records the winner in its in-service register, unless automatic end-of-interrupt is selected. The in-service bit is cleared later by a specific or a non-specific end-of-interrupt command.

If the request has vanished by the time of the acknowledge, the controller reports a level-7 vector and records nothing. Two controllers can be chained. A master holds a bitmask of the inputs that carry slaves, and a slave holds the number of the master input it drives.

Top module: `pic8_ctrl`

## Requirements
- R1: After synchronous reset the mask is 0xFF, the request and in-service registers are zero, int_out and vec_valid are low, and command-port reads return the request register.
- R2: A command write with bit 4 set starts configuration. It clears the in-service register, selects request read-back and clears automatic mode. The data writes that follow are taken in this order: the vector base (bits 7:3 kept), then the cascade word (only if bit 1 of the start byte is 0), then the mode word (only if bit 0 of the start byte is 1). These writes leave the mask untouched.
- R3: cascade_map shows the stored cascade word unchanged when slave_sel is 0, and only its low three bits (upper bits zero) when slave_sel is 1.
- R4: Once configuration is complete, a data write loads the mask. A 1 in the mask blocks that input from int_out and from the acknowledge, and the mask reads back on the data port.
- R5: A rising edge on irq_in[n] sets request bit n at the next clock, whether or not input n is masked. The bit clears when the input goes low or when that request is acknowledged.
- R6: int_out is high exactly when some unmasked pending request has a lower index than every set in-service bit. Input 0 has the highest priority.
- R7: One cycle after a one-cycle inta pulse, vec_valid is high and vec_out is {base[7:3], n}, where n is the winning input. The winner's request bit is cleared and, unless automatic mode is on, its in-service bit is set.
- R8: If no request qualifies at the acknowledge, vec_out is {base[7:3], 3'b111} and no in-service bit is set. This holds even when input 7 is masked.
- R9: Command byte 0x0B makes later command-port reads return the in-service register, and 0x0A makes them return the request register.
- R10: Command byte 0x60+k clears in-service bit k only.
- R11: Command byte 0x20 clears the lowest-index set in-service bit only.
- R12: When bit 1 of the mode word is 1, an acknowledge sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_data | input | 1 | Port select: 0 command, 1 data |
| wr_en | input | 1 | Write strobe for the selected port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte of the selected port |
| irq_in | input | 8 | Edge-triggered request inputs |
| slave_sel | input | 1 | 1 when this controller is a cascade slave |
| cascade_map | output | 8 | Stored cascade identity |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| vec_valid | output | 1 | Vector strobe, one cycle after inta |
| vec_out | output | 8 | Acknowledge vector |

## Verification
A single request is raised, acknowledged and then read back, so a wrong vector base, a wrong winner or a wrong choice of read-back register each shows up. Nested requests are raised below and above the active in-service level to separate the priority comparison from plain pending detection. The specific and non-specific end-of-interrupt commands are then applied to a two-bit in-service state, which tells them apart. A request that vanishes before its acknowledge checks the level-7 report. Configurations that skip the cascade word or the mode word, and a slave in automatic mode, confirm that data writes are steered in the right order.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    localparam int NUM_IRQ = 8;
    localparam int DW      = 8;
    localparam int LVL_W   = $clog2(NUM_IRQ);
    localparam int BASE_W  = DW - LVL_W;

    // command byte fields
    localparam int CMD_INIT_BIT  = 4;
    localparam int CMD_RSEL_BIT  = 3;
    localparam logic [2:0] EOI_SPEC_OP = 3'b011;
    localparam logic [2:0] EOI_LOW_OP  = 3'b001;

    typedef enum logic [1:0] {
        SEQ_READY,
        SEQ_BASE,
        SEQ_CASC,
        SEQ_MODE
    } seq_state_t;

    typedef enum logic [1:0] {
        EOI_NONE,
        EOI_SPECIFIC,
        EOI_LOWEST
    } eoi_kind_t;

    typedef struct packed {
        eoi_kind_t        kind;
        logic [LVL_W-1:0] level;
    } eoi_cmd_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              auto_eoi;
        logic [DW-1:0]     casc;
    } pic_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] idx;
    } pick_t;

    // lowest set index wins (index 0 has top priority)
    function automatic pick_t lowest_set(input logic [NUM_IRQ-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = LVL_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/pic8_reqlatch.sv
module pic8_reqlatch #(
    parameter int N = pic8_pkg::NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic prev_q;
        logic req_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                req_q  <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                // set on edge, drop when the line falls or when granted
                req_q  <= ((req_q & ~ack_clr[g]) | (irq_in[g] & ~prev_q)) & irq_in[g];
            end
        end

        assign irr[g] = req_q;
    end

endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve
    import pic8_pkg::*;
(
    input  logic [NUM_IRQ-1:0] irr,
    input  logic [NUM_IRQ-1:0] imr,
    input  logic [NUM_IRQ-1:0] isr,
    output logic               int_req,
    output pick_t              win,
    output pick_t              top
);

    logic [NUM_IRQ-1:0] eligible;

    always_comb begin
        logic run;
        run = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            run         = run | isr[i];
            eligible[i] = irr[i] & ~imr[i] & ~run;
        end
    end

    assign win     = lowest_set(eligible);
    assign top     = lowest_set(isr);
    assign int_req = win.hit;

endmodule

// File: rtl/pic8_regfile.sv
module pic8_regfile
    import pic8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          sel_data,
    input  logic [DW-1:0] wr_data,
    output pic_cfg_t      cfg,
    output logic [DW-1:0] imr,
    output logic          show_isr,
    output logic          init_clr,
    output eoi_cmd_t      eoi,
    output logic          seq_ready
);

    seq_state_t st_q;
    logic       want_mode_q;
    logic       single_q;
    logic       cmd_wr;
    logic       dat_wr;

    assign cmd_wr    = wr_en & ~sel_data;
    assign dat_wr    = wr_en & sel_data;
    assign init_clr  = cmd_wr & wr_data[CMD_INIT_BIT];
    assign seq_ready = (st_q == SEQ_READY);

    always_comb begin
        eoi       = '0;
        eoi.kind  = EOI_NONE;
        eoi.level = wr_data[LVL_W-1:0];
        if (cmd_wr && !wr_data[CMD_INIT_BIT] && !wr_data[CMD_RSEL_BIT]) begin
            if (wr_data[7:5] == EOI_SPEC_OP)
                eoi.kind = EOI_SPECIFIC;
            else if (wr_data[7:5] == EOI_LOW_OP)
                eoi.kind = EOI_LOWEST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SEQ_READY;
            cfg         <= '0;
            imr         <= '1;
            show_isr    <= 1'b0;
            want_mode_q <= 1'b0;
            single_q    <= 1'b0;
        end else if (init_clr) begin
            st_q         <= SEQ_BASE;
            want_mode_q  <= wr_data[0];
            single_q     <= wr_data[1];
            show_isr     <= 1'b0;
            cfg.auto_eoi <= 1'b0;
        end else if (cmd_wr && wr_data[CMD_RSEL_BIT] && wr_data[1]) begin
            show_isr <= wr_data[0];
        end else if (dat_wr) begin
            unique case (st_q)
                SEQ_BASE: begin
                    cfg.base <= wr_data[DW-1:LVL_W];
                    if (!single_q)
                        st_q <= SEQ_CASC;
                    else if (want_mode_q)
                        st_q <= SEQ_MODE;
                    else
                        st_q <= SEQ_READY;
                end
                SEQ_CASC: begin
                    cfg.casc <= wr_data;
                    st_q     <= want_mode_q ? SEQ_MODE : SEQ_READY;
                end
                SEQ_MODE: begin
                    cfg.auto_eoi <= wr_data[1];
                    st_q         <= SEQ_READY;
                end
                default: imr <= wr_data;
            endcase
        end
    end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_data,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               slave_sel,
    output logic [DW-1:0]      cascade_map,
    output logic               int_out,
    input  logic               inta,
    output logic               vec_valid,
    output logic [DW-1:0]      vec_out
);

    pic_cfg_t           cfg;
    eoi_cmd_t           eoi;
    pick_t              win;
    pick_t              top;
    logic [NUM_IRQ-1:0] irr_q;
    logic [NUM_IRQ-1:0] imr_q;
    logic [NUM_IRQ-1:0] isr_q;
    logic [NUM_IRQ-1:0] isr_n;
    logic [NUM_IRQ-1:0] ack_clr;
    logic               show_isr;
    logic               init_clr;
    logic               seq_ready;
    logic               int_req;
    logic               grant;

    pic8_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sel_data (sel_data),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .imr      (imr_q),
        .show_isr (show_isr),
        .init_clr (init_clr),
        .eoi      (eoi),
        .seq_ready(seq_ready)
    );

    pic8_reqlatch #(.N(NUM_IRQ)) u_req (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .ack_clr(ack_clr),
        .irr    (irr_q)
    );

    pic8_resolve u_pri (
        .irr    (irr_q),
        .imr    (imr_q),
        .isr    (isr_q),
        .int_req(int_req),
        .win    (win),
        .top    (top)
    );

    assign grant   = inta & win.hit;
    assign ack_clr = grant ? (NUM_IRQ'(1) << win.idx) : '0;
    assign int_out = int_req;

    always_comb begin
        isr_n = isr_q;
        if (eoi.kind == EOI_SPECIFIC)
            isr_n[eoi.level] = 1'b0;
        else if (eoi.kind == EOI_LOWEST && top.hit)
            isr_n[top.idx] = 1'b0;
        if (grant && !cfg.auto_eoi)
            isr_n[win.idx] = 1'b1;
        if (init_clr)
            isr_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q     <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            isr_q     <= isr_n;
            vec_valid <= inta;
            if (inta)
                vec_out <= {cfg.base, (win.hit ? win.idx : LVL_W'(NUM_IRQ - 1))};
        end
    end

    assign rd_data     = sel_data ? imr_q : (show_isr ? isr_q : irr_q);
    assign cascade_map = slave_sel ? {{(DW-LVL_W){1'b0}}, cfg.casc[LVL_W-1:0]} : cfg.casc;

endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
    import pic8_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               inta,
    input logic               vec_valid,
    input logic               int_out,
    input logic [NUM_IRQ-1:0] irr,
    input logic [NUM_IRQ-1:0] imr,
    input logic [NUM_IRQ-1:0] isr,
    input logic               wr_en,
    input logic               sel_data,
    input logic [DW-1:0]      wr_data,
    input logic               seq_ready
);

    p_ack_vec_r7: assert property (@(posedge clk) disable iff (rst)
        inta |=> vec_valid);

    p_no_ack_no_vec_r7: assert property (@(posedge clk) disable iff (rst)
        !inta |=> !vec_valid);

    p_int_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != '0));

    p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_data && seq_ready) |=> (imr == $past(wr_data)));

    p_spec_eoi_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel_data && wr_data[7:3] == 5'b01100 && !inta)
        |=> (isr[$past(wr_data[LVL_W-1:0])] == 1'b0));

    p_init_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel_data && wr_data[4]) |=> (isr == '0));

endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .inta     (inta),
    .vec_valid(vec_valid),
    .int_out  (int_out),
    .irr      (irr_q),
    .imr      (imr_q),
    .isr      (isr_q),
    .wr_en    (wr_en),
    .sel_data (sel_data),
    .wr_data  (wr_data),
    .seq_ready(seq_ready)
);

// File: tb/pic8_ctrl_tb.sv
`timescale 1ns/100ps
module pic8_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_data = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] irq_in = 8'h00;
    logic       slave_sel = 1'b0;
    logic [7:0] cascade_map;
    logic       int_out;
    logic       inta = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pic8_ctrl u_dut (
        .clk(clk), .rst(rst), .sel_data(sel_data), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
        .slave_sel(slave_sel), .cascade_map(cascade_map), .int_out(int_out),
        .inta(inta), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_irr, m_isr, m_imr, m_prev, m_cas, m_vec, clr, n_isr, n_irr;
    logic [4:0] m_base;
    logic       m_aeoi, m_rds, m_vv, m_w4, m_sng;
    int         m_st;

    function automatic logic model_int();
        int lo = 8;
        for (int i = 7; i >= 0; i--) if (m_isr[i]) lo = i;
        for (int i = 0; i < 8; i++) if (m_irr[i] && !m_imr[i] && i < lo) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0; m_base = 0; m_cas = 0;
            m_aeoi = 0; m_rds = 0; m_vv = 0; m_vec = 0; m_st = 0; m_w4 = 0; m_sng = 0;
        end else begin
            int lo;
            int win;
            lo = 8; win = -1;
            for (int i = 7; i >= 0; i--) if (m_isr[i]) lo = i;
            for (int i = 7; i >= 0; i--) if (m_irr[i] && !m_imr[i] && i < lo) win = i;
            clr = 0;
            if (inta && win >= 0) clr[win] = 1'b1;
            n_irr = ((m_irr & ~clr) | (irq_in & ~m_prev)) & irq_in;
            n_isr = m_isr;
            if (wr_en && !sel_data && !wr_data[4] && !wr_data[3]) begin
                if (wr_data[7:5] == 3'd3) n_isr[wr_data[2:0]] = 1'b0;
                else if (wr_data[7:5] == 3'd1 && lo < 8) n_isr[lo] = 1'b0;
            end
            if (inta && win >= 0 && !m_aeoi) n_isr[win] = 1'b1;
            if (wr_en && !sel_data && wr_data[4]) n_isr = 0;
            m_vv = inta;
            if (inta) m_vec = {m_base, (win >= 0) ? 3'(win) : 3'd7};
            if (wr_en && !sel_data) begin
                if (wr_data[4]) begin
                    m_st = 1; m_w4 = wr_data[0]; m_sng = wr_data[1]; m_rds = 0; m_aeoi = 0;
                end else if (wr_data[3] && wr_data[1]) m_rds = wr_data[0];
            end else if (wr_en && sel_data) begin
                case (m_st)
                    1: begin m_base = wr_data[7:3]; m_st = !m_sng ? 2 : (m_w4 ? 3 : 0); end
                    2: begin m_cas = wr_data; m_st = m_w4 ? 3 : 0; end
                    3: begin m_aeoi = wr_data[1]; m_st = 0; end
                    default: m_imr = wr_data;
                endcase
            end
            m_irr = n_irr; m_isr = n_isr; m_prev = irq_in;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6 int_out vs model", {7'd0, int_out}, {7'd0, model_int()});
            chk("R7 vec_valid vs model", {7'd0, vec_valid}, {7'd0, m_vv});
            if (m_vv) chk("R7/R8 vec_out vs model", vec_out, m_vec);
            chk("R9/R4 rd_data vs model", rd_data,
                sel_data ? m_imr : (m_rds ? m_isr : m_irr));
            chk("R3 cascade_map vs model", cascade_map,
                slave_sel ? {5'd0, m_cas[2:0]} : m_cas);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic op(input logic a, input logic [7:0] d, input logic wr, input logic ack);
        @(posedge clk); #1;
        sel_data = a; wr_data = d; wr_en = wr; inta = ack;
        @(posedge clk); #1;
        wr_en = 1'b0; inta = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d);  op(1'b0, d, 1'b1, 1'b0); endtask
    task automatic dat(input logic [7:0] d);  op(1'b1, d, 1'b1, 1'b0); endtask
    task automatic ack();                     op(1'b0, 8'h00, 1'b0, 1'b1); endtask

    task automatic set_irq(input logic [7:0] v);
        @(posedge clk); #1; irq_in = v;
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        sel_data = a; #0.2; v = rd_data;
    endtask

    logic [7:0] r;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #0.5;
        rd(1'b0, r); chk("R1 request reg after reset", r, 8'h00);
        rd(1'b1, r); chk("R1 mask after reset", r, 8'hFF);
        chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'h00);

        // master, cascade word, mode word without auto mode
        cmd(8'h11); dat(8'h20); dat(8'h04);
        rd(1'b1, r); chk("R2 mask untouched during sequence", r, 8'hFF);
        dat(8'h01);
        chk("R3 master cascade word", cascade_map, 8'h04);
        dat(8'h00);
        rd(1'b1, r); chk("R4 mask load", r, 8'h00);

        set_irq(8'h20);
        rd(1'b0, r); chk("R5 edge sets request", r, 8'h20);
        chk("R6 int_out for pending 5", {7'd0, int_out}, 8'h01);
        ack();
        chk("R7 vec_valid after ack", {7'd0, vec_valid}, 8'h01);
        chk("R7 vector for input 5", vec_out, 8'h25);
        cmd(8'h0B); rd(1'b0, r); chk("R9 in-service read", r, 8'h20);
        cmd(8'h0A); rd(1'b0, r); chk("R9/R7 request read cleared", r, 8'h00);

        // nesting
        set_irq(8'h28);
        chk("R6 higher request breaks through", {7'd0, int_out}, 8'h01);
        ack(); chk("R7 vector for input 3", vec_out, 8'h23);
        set_irq(8'h68);
        chk("R6 lower request blocked", {7'd0, int_out}, 8'h00);
        cmd(8'h0B); rd(1'b0, r); chk("R7 nested in-service", r, 8'h28);
        cmd(8'h63); rd(1'b0, r); chk("R10 specific EOI level 3", r, 8'h20);
        chk("R6 still blocked by 5", {7'd0, int_out}, 8'h00);
        cmd(8'h20); rd(1'b0, r); chk("R11 non-specific EOI", r, 8'h00);
        chk("R6 input 6 now raises int", {7'd0, int_out}, 8'h01);
        ack(); chk("R7 vector for input 6", vec_out, 8'h26);
        cmd(8'h66); rd(1'b0, r); chk("R10 specific EOI level 6", r, 8'h00);
        cmd(8'h0A);

        // masking
        set_irq(8'h00);
        dat(8'h02);
        set_irq(8'h02);
        rd(1'b0, r); chk("R5 masked input still latched", r, 8'h02);
        chk("R4 masked input no int", {7'd0, int_out}, 8'h00);
        dat(8'h00);
        chk("R4 unmask raises int", {7'd0, int_out}, 8'h01);
        ack(); chk("R7 vector for input 1", vec_out, 8'h21);
        cmd(8'h61);

        // spurious report with input 7 masked
        dat(8'h80);
        set_irq(8'h06);
        chk("R6 int for input 2", {7'd0, int_out}, 8'h01);
        set_irq(8'h02);
        chk("R5 request drops with input", {7'd0, int_out}, 8'h00);
        ack(); chk("R8 spurious vector", vec_out, 8'h27);
        cmd(8'h0B); rd(1'b0, r); chk("R8 no in-service bit", r, 8'h00);
        cmd(8'h0A);

        // slave, automatic mode
        set_irq(8'h00);
        slave_sel = 1'b1;
        cmd(8'h11); dat(8'h28); dat(8'h02); dat(8'h03);
        chk("R3 slave identity", cascade_map, 8'h02);
        dat(8'h00);
        set_irq(8'h10);
        ack(); chk("R7 slave vector input 4", vec_out, 8'h2C);
        cmd(8'h0B); rd(1'b0, r); chk("R12 auto mode leaves in-service clear", r, 8'h00);
        cmd(8'h0A);

        // single mode: cascade word skipped
        set_irq(8'h00);
        slave_sel = 1'b0;
        cmd(8'h13); dat(8'h30); dat(8'h01); dat(8'hA5);
        rd(1'b1, r); chk("R2 cascade word skipped, mask loaded", r, 8'hA5);
        chk("R2 cascade word kept", cascade_map, 8'h02);

        // no mode word
        cmd(8'h12); dat(8'h48); dat(8'h5A);
        rd(1'b1, r); chk("R2 mode word skipped, mask loaded", r, 8'h5A);
        dat(8'hFE);
        set_irq(8'h01);
        ack(); chk("R2 new base in vector", vec_out, 8'h48);
        cmd(8'h0B); rd(1'b0, r); chk("R2 auto mode cleared by restart", r, 8'h01);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule